// File: doc/BRIEF.md
# Interrupt Vector Table and Pending-Bit Register File

This block is a memory-mapped register file for message-signalled interrupt vectors. A single 4 KiB window holds two regions. The lower half is a table of per-vector entries, each 16 bytes long. The upper half, starting at byte offset 0x800, is a read-only array of pending bits. The decoded 12-bit window offset comes in over a plain 32-bit register port. Each access carries a read strobe, a write strobe, an access-size code, write data and registered read data. A one-cycle error strobe flags any access narrower than a full word.

Each vector's 64-bit message address, its 32-bit message data and its mask bit are driven out continuously to the message dispatcher. The dispatcher owns the pending bits: it sets them when a masked vector fires and clears them once a message has gone out. Every accepted word write into the table region raises a one-cycle update event that carries the vector index of the written entry, so the mask logic can re-evaluate that vector.

Top module: `vec_table_regs`

## Requirements
- R1: After reset every table word reads zero except the control word of each implemented vector, which reads 1. All pending bits are zero and `vec_mask` is all ones.
- R2: Entry v occupies offsets 16v to 16v+15. The low address word is at +0, the high address word at +4, the data word at +8 and the control word at +12. `vec_addr` slice v is {high, low}, `vec_data` slice v is the data word, and both read back as written.
- R3: Bit 0 of an entry's control word is that vector's mask bit on `vec_mask`. The other control bits are stored and read back, but have no effect on the mask.
- R4: The two low offset bits are ignored, so any offset within a word addresses that whole word.
- R5: Only accesses with `bus_size` = 2 (word) are legal. Codes 0 (byte), 1 (halfword) and 3 are illegal. An illegal read returns zero, and an illegal write changes nothing and raises no update event. Both pulse `bus_err` high for one cycle, in the cycle after the access.
- R6: `bus_rdata` presents the value read, one cycle after a legal read strobe. It shows the state as it was before any write in the same cycle, and it is zero in every other cycle.
- R7: Every legal word write to an offset below 0x800 pulses `upd_valid` for exactly one cycle, in the cycle after the write. `upd_vec` then equals the offset divided by 16 (0 to 127), whether or not that entry is implemented.
- R8: Table offsets of entries at or beyond NUM_VEC read zero, and writes to them store nothing.
- R9: The pending word at 0x800 carries vector v's bit at bit position v, which is bit (v mod 8) of byte (v / 8). Words above 0x800 read zero.
- R10: A bit of `pend_set` sets, and a bit of `pend_clr` clears, the matching pending bit on the next cycle. When both target the same bit, set wins. `pend_bits` shows the array.
- R11: Bus writes to the pending region change no pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte offset within the 4 KiB window |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Illegal-size access, one-cycle pulse |
| pend_set | input | NUM_VEC | Set pending bits |
| pend_clr | input | NUM_VEC | Clear pending bits |
| vec_addr | output | 64*NUM_VEC | Per-vector 64-bit message address |
| vec_data | output | 32*NUM_VEC | Per-vector message data |
| vec_mask | output | NUM_VEC | Per-vector mask bit |
| pend_bits | output | NUM_VEC | Pending bit array |
| upd_valid | output | 1 | Table-write update event |
| upd_vec | output | 7 | Vector index of the update event |

## Verification
The directed patterns come first. Word writes and read-backs at each of the four entry offsets show whether the field layout and the address and data outputs are wired correctly. Misaligned offsets and narrow sizes aimed at the same word separate offset masking from size rejection. Writes just past the last implemented entry and near the top of the table region show that the update event is reported independently of storage. Overlapping pending set and clear pulses, together with bus writes into the pending region, expose the wrong priority or a writable array. Mixed random traffic is then checked cycle by cycle against a behavioural model.

// File: rtl/vtr_pkg.sv
package vtr_pkg;
    localparam int          OFF_W       = 12;
    localparam int          IDX_W       = 7;
    localparam int          MAX_VEC     = 32;
    localparam int          CTRL_WORD   = 3;
    localparam int          MASK_BIT    = 0;
    localparam logic [1:0]  SZ_WORD     = 2'd2;

    typedef struct packed {
        logic             legal;
        logic             bad;
        logic             is_tab;
        logic [IDX_W-1:0] vec;
        logic [1:0]       word;
        logic [8:0]       pword;
    } dec_t;
endpackage

// File: rtl/vtr_decode.sv
module vtr_decode
    import vtr_pkg::*;
(
    input  logic [OFF_W-1:0] addr,
    input  logic [1:0]       size,
    input  logic             rd,
    input  logic             wr,
    output dec_t             dec
);
    always_comb begin
        dec        = '0;
        dec.legal  = (rd | wr) && (size == SZ_WORD);
        dec.bad    = (rd | wr) && (size != SZ_WORD);
        dec.is_tab = ~addr[OFF_W-1];
        dec.vec    = addr[10:4];
        dec.word   = addr[3:2];
        dec.pword  = addr[10:2];
    end
endmodule

// File: rtl/vtr_entry_store.sv
module vtr_entry_store
    import vtr_pkg::*;
#(
    parameter int NUM_VEC = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  logic [IDX_W-1:0]                  vec,
    input  logic [1:0]                        word,
    input  logic [31:0]                       wdata,
    output logic [NUM_VEC-1:0][3:0][31:0]     ent_o
);
    localparam int VI_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

    typedef struct packed {
        logic [NUM_VEC-1:0][3:0][31:0] ent;
    } st_t;

    st_t st_d, st_q;

    function automatic st_t reset_image();
        st_t r;
        r = '0;
        for (int v = 0; v < NUM_VEC; v++) begin
            r.ent[v][CTRL_WORD][MASK_BIT] = 1'b1;
        end
        return r;
    endfunction

    always_comb begin
        st_d = st_q;
        if (we && (vec < IDX_W'(NUM_VEC))) begin
            st_d.ent[vec[VI_W-1:0]][word] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= reset_image();
        else        st_q <= st_d;
    end

    assign ent_o = st_q.ent;
endmodule

// File: rtl/vtr_pend_array.sv
module vtr_pend_array #(
    parameter int NUM_VEC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] set_i,
    input  logic [NUM_VEC-1:0] clr_i,
    output logic [NUM_VEC-1:0] bits_o
);
    typedef struct packed {
        logic [NUM_VEC-1:0] bits;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.bits = (st_q.bits & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bits_o = st_q.bits;
endmodule

// File: rtl/vec_table_regs.sv
module vec_table_regs
    import vtr_pkg::*;
#(
    parameter int NUM_VEC = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [11:0]             bus_addr,
    input  logic [1:0]              bus_size,
    input  logic                    bus_rd,
    input  logic                    bus_wr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    output logic                    bus_err,
    input  logic [NUM_VEC-1:0]      pend_set,
    input  logic [NUM_VEC-1:0]      pend_clr,
    output logic [64*NUM_VEC-1:0]   vec_addr,
    output logic [32*NUM_VEC-1:0]   vec_data,
    output logic [NUM_VEC-1:0]      vec_mask,
    output logic [NUM_VEC-1:0]      pend_bits,
    output logic                    upd_valid,
    output logic [6:0]              upd_vec
);
    localparam int VI_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

    typedef struct packed {
        logic [31:0]      rdata;
        logic             err;
        logic             upd;
        logic [IDX_W-1:0] uvec;
    } out_t;

    dec_t                          dec;
    logic [NUM_VEC-1:0][3:0][31:0] ent;
    logic                          tab_we;
    logic                          vec_impl;
    out_t                          out_d, out_q;

    vtr_decode u_dec (
        .addr (bus_addr),
        .size (bus_size),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .dec  (dec)
    );

    assign tab_we   = bus_wr && dec.legal && dec.is_tab;
    assign vec_impl = dec.vec < IDX_W'(NUM_VEC);

    vtr_entry_store #(.NUM_VEC(NUM_VEC)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tab_we),
        .vec   (dec.vec),
        .word  (dec.word),
        .wdata (bus_wdata),
        .ent_o (ent)
    );

    vtr_pend_array #(.NUM_VEC(NUM_VEC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (pend_set),
        .clr_i  (pend_clr),
        .bits_o (pend_bits)
    );

    always_comb begin
        out_d      = '0;
        out_d.err  = dec.bad;
        out_d.upd  = tab_we;
        out_d.uvec = dec.vec;
        if (bus_rd && dec.legal) begin
            if (dec.is_tab) begin
                if (vec_impl) out_d.rdata = ent[dec.vec[VI_W-1:0]][dec.word];
            end else if (dec.pword == '0) begin
                out_d.rdata = 32'(pend_bits);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign bus_rdata = out_q.rdata;
    assign bus_err   = out_q.err;
    assign upd_valid = out_q.upd;
    assign upd_vec   = out_q.uvec;

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        assign vec_addr[64*v +: 64] = {ent[v][1], ent[v][0]};
        assign vec_data[32*v +: 32] = ent[v][2];
        assign vec_mask[v]          = ent[v][CTRL_WORD][MASK_BIT];
    end
endmodule

// File: rtl/vtr_chk.sv
module vtr_chk #(
    parameter int NUM_VEC = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [11:0]        bus_addr,
    input logic [1:0]         bus_size,
    input logic               bus_rd,
    input logic               bus_wr,
    input logic [31:0]        bus_rdata,
    input logic               bus_err,
    input logic [NUM_VEC-1:0] pend_set,
    input logic [NUM_VEC-1:0] pend_clr,
    input logic [NUM_VEC-1:0] vec_mask,
    input logic [NUM_VEC-1:0] pend_bits,
    input logic               upd_valid,
    input logic [6:0]         upd_vec
);
    AST_BAD_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && bus_size != 2'd2) |=> bus_err); // R5
    AST_ERR_ONLY_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        !((bus_rd || bus_wr) && bus_size != 2'd2) |=> !bus_err); // R5
    AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_size != 2'd2) |=> bus_rdata == 32'd0); // R5
    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == 32'd0); // R6
    AST_UPD_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_size == 2'd2 && !bus_addr[11]) |=>
            (upd_valid && upd_vec == $past(bus_addr[10:4]))); // R7
    AST_NO_SPURIOUS_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_size == 2'd2 && !bus_addr[11]) |=> !upd_valid); // R7
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(vec_mask)); // R3
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_set != '0) |=> ((pend_bits & $past(pend_set)) == $past(pend_set))); // R10
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_clr & ~pend_set) != '0) |=> ((pend_bits & $past(pend_clr & ~pend_set)) == '0)); // R10
    AST_PEND_BUS_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_set == '0 && pend_clr == '0) |=> $stable(pend_bits)); // R11
endmodule

bind vec_table_regs vtr_chk #(.NUM_VEC(NUM_VEC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .pend_set  (pend_set),
    .pend_clr  (pend_clr),
    .vec_mask  (vec_mask),
    .pend_bits (pend_bits),
    .upd_valid (upd_valid),
    .upd_vec   (upd_vec)
);

// File: tb/sim_vec_table_regs.sv
`timescale 1ns/1ps
module sim_vec_table_regs;
    localparam int NV = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic [1:0]        bus_size = 2'd2;
    logic              bus_rd = 1'b0;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_err;
    logic [NV-1:0]     pend_set = '0;
    logic [NV-1:0]     pend_clr = '0;
    logic [64*NV-1:0]  vec_addr;
    logic [32*NV-1:0]  vec_data;
    logic [NV-1:0]     vec_mask;
    logic [NV-1:0]     pend_bits;
    logic              upd_valid;
    logic [6:0]        upd_vec;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vec_table_regs #(.NUM_VEC(NV)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .pend_set(pend_set),
        .pend_clr(pend_clr), .vec_addr(vec_addr), .vec_data(vec_data),
        .vec_mask(vec_mask), .pend_bits(pend_bits), .upd_valid(upd_valid),
        .upd_vec(upd_vec)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Behavioural reference model
    logic [31:0] m_tab [NV][4];
    logic [NV-1:0] m_pend;
    logic [31:0] m_rdata;
    logic m_err, m_upd;
    logic [6:0] m_uvec;

    always @(posedge clk) begin
        int off;
        logic [31:0] r;
        cyc++;
        if (!rst_n) begin
            for (int v = 0; v < NV; v++)
                for (int w = 0; w < 4; w++) m_tab[v][w] <= (w == 3) ? 32'd1 : 32'd0;
            m_pend <= '0; m_rdata <= '0; m_err <= 1'b0; m_upd <= 1'b0; m_uvec <= '0;
        end else begin
            off = int'(bus_addr) / 4 * 4;
            r = 32'd0;
            if (bus_rd && bus_size == 2'd2) begin
                if (off < 2048) begin
                    if (off / 16 < NV) r = m_tab[off / 16][(off % 16) / 4];
                end else if (off == 2048) begin
                    for (int v = 0; v < NV; v++)
                        if (m_pend[v]) r = r | (32'd1 << ((v / 8) * 8 + (v % 8)));
                end
            end
            m_rdata <= r;
            m_err   <= (bus_rd || bus_wr) && bus_size != 2'd2;
            m_upd   <= bus_wr && bus_size == 2'd2 && off < 2048;
            m_uvec  <= 7'((off % 2048) / 16);
            if (bus_wr && bus_size == 2'd2 && off < 2048 && off / 16 < NV)
                m_tab[off / 16][(off % 16) / 4] <= bus_wdata;
            for (int v = 0; v < NV; v++) begin
                if (pend_set[v])      m_pend[v] <= 1'b1;
                else if (pend_clr[v]) m_pend[v] <= 1'b0;
            end
        end
    end

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(bus_rdata == m_rdata, "R6 rdata", 64'(bus_rdata), 64'(m_rdata));
            chk(bus_err == m_err, "R5 err", 64'(bus_err), 64'(m_err));
            chk(upd_valid == m_upd, "R7 upd_valid", 64'(upd_valid), 64'(m_upd));
            if (m_upd) chk(upd_vec == m_uvec, "R7 upd_vec", 64'(upd_vec), 64'(m_uvec));
            chk(pend_bits == m_pend, "R10 pend_bits", 64'(pend_bits), 64'(m_pend));
            for (int v = 0; v < NV; v++) begin
                chk(vec_mask[v] == m_tab[v][3][0], "R3 vec_mask", 64'(vec_mask[v]), 64'(m_tab[v][3][0]));
                chk(vec_addr[64*v +: 64] == {m_tab[v][1], m_tab[v][0]}, "R2 vec_addr",
                    vec_addr[64*v +: 64], {m_tab[v][1], m_tab[v][0]});
                chk(vec_data[32*v +: 32] == m_tab[v][2], "R2 vec_data",
                    64'(vec_data[32*v +: 32]), 64'(m_tab[v][2]));
            end
        end
    end

    task automatic access(input logic [11:0] a, input logic [1:0] sz, input bit rd, input bit wr, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_rd = rd; bus_wr = wr; bus_wdata = d;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr32(input logic [11:0] a, input logic [31:0] d);
        access(a, 2'd2, 1'b0, 1'b1, d);
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
        access(a, 2'd2, 1'b1, 1'b0, 32'd0);
        chk(bus_rdata == exp, req, 64'(bus_rdata), 64'(exp));
    endtask

    task automatic pend_pulse(input logic [NV-1:0] s, input logic [NV-1:0] c);
        @(negedge clk);
        pend_set = s; pend_clr = c;
        @(negedge clk);
        pend_set = '0; pend_clr = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset image
        chk(vec_mask == '1, "R1 mask after reset", 64'(vec_mask), 64'('1));
        rd_chk(12'h000, 32'd0, "R1 vec0 low addr");
        rd_chk(12'((NV-1)*16 + 12), 32'd1, "R1 last ctrl word");
        rd_chk(12'h800, 32'd0, "R1 pending zero");
        // R2 layout
        wr32(12'h030, 32'hA000_1000);
        wr32(12'h034, 32'h0000_00B7);
        wr32(12'h038, 32'hC0DE_0003);
        rd_chk(12'h030, 32'hA000_1000, "R2 low addr readback");
        rd_chk(12'h034, 32'h0000_00B7, "R2 high addr readback");
        rd_chk(12'h038, 32'hC0DE_0003, "R2 data readback");
        chk(vec_addr[64*3 +: 64] == 64'h0000_00B7_A000_1000, "R2 vec_addr slice", vec_addr[64*3 +: 64], 64'h0000_00B7_A000_1000);
        // R3 mask bit
        wr32(12'h03C, 32'd0);
        chk(vec_mask[3] == 1'b0, "R3 unmask", 64'(vec_mask[3]), 64'd0);
        wr32(12'h03C, 32'hFFFF_FFFE);
        chk(vec_mask[3] == 1'b0, "R3 upper bits no effect", 64'(vec_mask[3]), 64'd0);
        rd_chk(12'h03F, 32'hFFFF_FFFE, "R3 ctrl readback");
        // R4 low bits ignored
        wr32(12'h052, 32'h1234_5678);
        rd_chk(12'h051, 32'h1234_5678, "R4 aliased word");
        // R5 narrow accesses
        access(12'h050, 2'd0, 1'b0, 1'b1, 32'hDEAD_BEEF);
        chk(bus_err == 1'b1, "R5 byte write err", 64'(bus_err), 64'd1);
        chk(upd_valid == 1'b0, "R5 no event", 64'(upd_valid), 64'd0);
        rd_chk(12'h050, 32'h1234_5678, "R5 write discarded");
        access(12'h050, 2'd1, 1'b1, 1'b0, 32'd0);
        chk(bus_rdata == 32'd0, "R5 half read zero", 64'(bus_rdata), 64'd0);
        chk(bus_err == 1'b1, "R5 half read err", 64'(bus_err), 64'd1);
        // R7 / R8 event beyond implemented entries
        wr32(12'h7F4, 32'h5555_AAAA);
        chk(upd_valid && upd_vec == 7'd127, "R7 event vec 127", 64'(upd_vec), 64'd127);
        rd_chk(12'h7F4, 32'd0, "R8 far entry reads zero");
        wr32(12'(NV*16), 32'h7777_7777);
        chk(upd_vec == 7'(NV), "R7 event first unimplemented", 64'(upd_vec), 64'(NV));
        rd_chk(12'(NV*16), 32'd0, "R8 unimplemented reads zero");
        // R9 / R10 pending
        pend_pulse(8'h42, 8'h00);
        rd_chk(12'h800, 32'h42, "R9 pending word");
        pend_pulse(8'h02, 8'h42);
        rd_chk(12'h800, 32'h02, "R10 set wins clear takes");
        rd_chk(12'h804, 32'd0, "R9 upper pending word zero");
        // R11 pending read-only from bus
        wr32(12'h800, 32'hFFFF_FFFF);
        rd_chk(12'h800, 32'h02, "R11 bus write ignored");
        // mixed random traffic, compared every cycle
        for (int i = 0; i < 3000; i++) begin
            int sel;
            logic [11:0] a;
            sel = int'($urandom % 4);
            case (sel)
                0: a = 12'($urandom % (NV * 16));
                1: a = 12'($urandom);
                2: a = 12'h800 + 12'($urandom % 16);
                default: a = 12'($urandom % 2048);
            endcase
            @(negedge clk);
            bus_addr = a;
            bus_size = ($urandom % 4 == 0) ? 2'($urandom) : 2'd2;
            bus_rd = 1'($urandom);
            bus_wr = 1'($urandom);
            bus_wdata = $urandom;
            pend_set = ($urandom % 3 == 0) ? NV'($urandom) : '0;
            pend_clr = ($urandom % 3 == 0) ? NV'($urandom) : '0;
        end
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; pend_set = '0; pend_clr = '0;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule